// File: doc/BRIEF.md
# Beam Timing Header Generator

This block produces the header word that accompanies every charge sample sent by the front-end boards in a crate. It runs on the accelerator RF clock. It makes its own sampling strobe at two-sevenths of the RF rate, and it keeps five free-running timing counters:
- proton turns
- antiproton turns
- turns of either beam
- sampling periods
- RF cycles

A source-select input picks which counter goes into the timing field of the header. Beam markers and the injection signal can arrive on any RF edge. Each one is caught in a hold flag and reported in the header word of the sample period it fell in.

A pulse on the acquisition-start input clears all counters and restarts the sampling phase. This gives every board the same time origin. The header leaves the block as a stream with valid/ready signalling. A new word is produced on every sampling strobe and raises `hdr_valid`. While `hdr_valid` is high and `hdr_ready` is low, the word is held unchanged. The sample stream is real-time and cannot be stalled. So if a word is still waiting when the next strobe comes, the newer word replaces it: back-pressure can delay a header but never hold up the samples.

Top module: `beam_hdr_gen`

## Requirements
- R1: `smp_tick` is high for one RF cycle at a time. It fires twice in every seven RF cycles, and the gaps between strobes alternate 3 and 4 cycles. The first strobe is on the 3rd RF cycle after an acquisition start.
- R2: The timing field is `hdr_word[8:0]`, the low 9 bits of the counter chosen by `src_sel`: 0 = proton turns, 1 = antiproton turns, 2 = turns of either beam, 3 = sampling periods, 4 or above = RF cycles. The field shows the counter value just before the strobe edge.
- R3: The either-beam counter advances by one when a proton marker, an antiproton marker, or both arrive on the same edge. Each of the single-beam counters counts only its own beam's markers.
- R4: Bit 13 of the header is `cal_mode` and bit 10 is `data_valid`, both sampled on the strobe edge.
- R5: A pulse on `proton_mark`, `pbar_mark` or `inj_mark` sets header bit 12, 11 or 9 respectively in the next header word. The bit is clear in the word after that, unless a new pulse arrives.
- R6: A marker pulse that arrives on the same edge that latches a header word is not shown in that word. It appears in the following word.
- R7: `src_sel` is captured only on strobe edges. A value captured on one strobe edge applies from the header word of the next strobe.
- R8: `acq_start` clears all five counters and the marker hold flags, and sets the sampling phase back to its start. No strobe occurs in the cycle after it.
- R9: `hdr_valid` rises on every strobe edge. It falls after a handshake (`hdr_valid` and `hdr_ready` both high) in a cycle with no strobe. While it waits it keeps `hdr_word` stable.
- R10: Counters are 16 bits wide internally, so the 9-bit timing field wraps from 511 back to 0.
- R11: After reset, `hdr_valid` is low, `hdr_word` is zero and the source is proton turns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RF clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_start | input | 1 | One-cycle pulse that restarts acquisition |
| proton_mark | input | 1 | Proton revolution marker pulse |
| pbar_mark | input | 1 | Antiproton revolution marker pulse |
| inj_mark | input | 1 | Injection event pulse |
| data_valid | input | 1 | Data/no-data level, sampled per header |
| cal_mode | input | 1 | Sampling mode level: 1 = calibration, 0 = auto-ranging |
| src_sel | input | 3 | Timing-field source select |
| hdr_ready | input | 1 | Downstream ready for the header word |
| smp_tick | output | 1 | Sampling strobe, two per seven RF cycles |
| hdr_valid | output | 1 | Header word is valid |
| hdr_word | output | 14 | Header word |

## Verification
Each counter source is run after a fresh acquisition start, so the expected field values can be worked out by hand: the RF source must read 3, 6 and 10, and the sampling source must read 0, 1 and 2. These values separate a wrong strobe phase from a wrong source. Proton and antiproton pulses, some on the same edge, tell the either-beam counter apart from a plain sum of the two beams. Markers are placed both in mid-period and exactly on a strobe edge, which shows whether a marker lands in the right word and whether its flag is cleared afterwards. A change of `src_sel` in mid-period and a stalled `hdr_ready` show that the source changes only at a period boundary and that a waiting word stays stable. A long RF run checks the 9-bit wrap.

// File: rtl/bthg_pkg.sv
package bthg_pkg;
  localparam int HDR_W  = 14;
  localparam int TIME_W = 9;
  localparam int NSRC   = 5;

  typedef enum logic [2:0] {
    SRC_PROTON = 3'd0,
    SRC_PBAR   = 3'd1,
    SRC_EITHER = 3'd2,
    SRC_SAMPLE = 3'd3,
    SRC_RF     = 3'd4
  } src_e;

  typedef struct packed {
    logic              cal;
    logic              proton;
    logic              pbar;
    logic              dvalid;
    logic              inject;
    logic [TIME_W-1:0] tfield;
  } hdr_t;
endpackage

// File: rtl/bthg_phase.sv
module bthg_phase #(
  parameter int PH_LEN = 7,
  parameter int TICK_A = 3,
  parameter int TICK_B = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PH_W = $clog2(PH_LEN);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ph_q <= '0;
    else if (clr)                            ph_q <= '0;
    else if (ph_q == PH_W'(PH_LEN - 1))      ph_q <= '0;
    else                                     ph_q <= ph_q + 1'b1;
  end

  assign tick = (ph_q == PH_W'(TICK_A)) || (ph_q == PH_W'(TICK_B));
endmodule

// File: rtl/bthg_ctr_bank.sv
module bthg_ctr_bank #(
  parameter int NCNT  = 5,
  parameter int CNT_W = 16,
  parameter int OUT_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [NCNT-1:0]      inc,
  output logic [OUT_W-1:0]     low [NCNT]
);
  for (genvar i = 0; i < NCNT; i++) begin : g_ctr
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (inc[i]) cnt_q <= cnt_q + 1'b1;
    end

    assign low[i] = cnt_q[OUT_W-1:0];
  end
endmodule

// File: rtl/bthg_sticky.sv
module bthg_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [N-1:0] ev,
  output logic [N-1:0] held
);
  for (genvar i = 0; i < N; i++) begin : g_hold
    logic h_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    h_q <= 1'b0;
      else if (clr)  h_q <= 1'b0;
      else if (tick) h_q <= ev[i];
      else           h_q <= h_q | ev[i];
    end

    assign held[i] = h_q;
  end
endmodule

// File: rtl/beam_hdr_gen.sv
module beam_hdr_gen
  import bthg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PH_LEN = 7,
  parameter int TICK_A = 3,
  parameter int TICK_B = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_start,
  input  logic             proton_mark,
  input  logic             pbar_mark,
  input  logic             inj_mark,
  input  logic             data_valid,
  input  logic             cal_mode,
  input  logic [2:0]       src_sel,
  input  logic             hdr_ready,
  output logic             smp_tick,
  output logic             hdr_valid,
  output logic [HDR_W-1:0] hdr_word
);
  localparam int NMARK = 3;

  logic              tick;
  logic [NSRC-1:0]   inc;
  logic [TIME_W-1:0] low [NSRC];
  logic [NMARK-1:0]  held;
  logic [TIME_W-1:0] tsel;
  src_e              src_q;
  hdr_t              hdr_q;
  logic              vld_q;

  bthg_phase #(.PH_LEN(PH_LEN), .TICK_A(TICK_A), .TICK_B(TICK_B)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(acq_start), .tick(tick)
  );

  always_comb begin
    inc = '0;
    inc[SRC_PROTON] = proton_mark;
    inc[SRC_PBAR]   = pbar_mark;
    inc[SRC_EITHER] = proton_mark | pbar_mark;
    inc[SRC_SAMPLE] = tick;
    inc[SRC_RF]     = 1'b1;
  end

  bthg_ctr_bank #(.NCNT(NSRC), .CNT_W(CNT_W), .OUT_W(TIME_W)) u_ctrs (
    .clk(clk), .rst_n(rst_n), .clr(acq_start), .inc(inc), .low(low)
  );

  bthg_sticky #(.N(NMARK)) u_marks (
    .clk(clk), .rst_n(rst_n), .clr(acq_start), .tick(tick),
    .ev({inj_mark, pbar_mark, proton_mark}), .held(held)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    src_q <= SRC_PROTON;
    else if (tick) src_q <= (src_sel > 3'd4) ? SRC_RF : src_e'(src_sel);
  end

  always_comb begin
    case (src_q)
      SRC_PROTON: tsel = low[SRC_PROTON];
      SRC_PBAR:   tsel = low[SRC_PBAR];
      SRC_EITHER: tsel = low[SRC_EITHER];
      SRC_SAMPLE: tsel = low[SRC_SAMPLE];
      default:    tsel = low[SRC_RF];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      vld_q <= 1'b0;
    end else if (tick) begin
      hdr_q.cal    <= cal_mode;
      hdr_q.proton <= held[0];
      hdr_q.pbar   <= held[1];
      hdr_q.dvalid <= data_valid;
      hdr_q.inject <= held[2];
      hdr_q.tfield <= tsel;
      vld_q        <= 1'b1;
    end else if (vld_q && hdr_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign smp_tick  = tick;
  assign hdr_valid = vld_q;
  assign hdr_word  = hdr_q;
endmodule

// File: rtl/beam_hdr_gen_chk.sv
module beam_hdr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acq_start,
  input logic        smp_tick,
  input logic        hdr_ready,
  input logic        hdr_valid,
  input logic [13:0] hdr_word
);
  logic [2:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap_q <= '0;
    else if (acq_start || smp_tick)  gap_q <= '0;
    else if (gap_q != 3'd7)          gap_q <= gap_q + 1'b1;
  end

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == 3'd3) |-> smp_tick);

  p_tick_spread_r1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick |=> !smp_tick ##1 !smp_tick);

  p_tick_after_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> !smp_tick);

  p_valid_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick |=> hdr_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_ready && !smp_tick) |=> (hdr_valid && $stable(hdr_word)));
endmodule

bind beam_hdr_gen beam_hdr_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .smp_tick(smp_tick),
  .hdr_ready(hdr_ready), .hdr_valid(hdr_valid), .hdr_word(hdr_word)
);

// File: tb/beam_hdr_gen_tb_top.sv
module beam_hdr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acq_start = 1'b0;
  logic        proton_mark = 1'b0;
  logic        pbar_mark = 1'b0;
  logic        inj_mark = 1'b0;
  logic        data_valid = 1'b0;
  logic        cal_mode = 1'b0;
  logic [2:0]  src_sel = 3'd0;
  logic        hdr_ready = 1'b1;
  logic        smp_tick;
  logic        hdr_valid;
  logic [13:0] hdr_word;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  beam_hdr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .proton_mark(proton_mark),
    .pbar_mark(pbar_mark), .inj_mark(inj_mark), .data_valid(data_valid),
    .cal_mode(cal_mode), .src_sel(src_sel), .hdr_ready(hdr_ready),
    .smp_tick(smp_tick), .hdr_valid(hdr_valid), .hdr_word(hdr_word)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks enter and leave at a falling edge.
  task automatic wait_word(output logic [13:0] w);
    while (!smp_tick) @(negedge clk);
    @(negedge clk);
    w = hdr_word;
  endtask

  task automatic start_acq();
    acq_start = 1'b1;
    @(negedge clk);
    acq_start = 1'b0;
  endtask

  task automatic set_src(input logic [2:0] s);
    logic [13:0] w;
    src_sel = s;
    wait_word(w);
  endtask

  task automatic t_reset();
    check(hdr_valid == 1'b0, "R11 valid low", int'(hdr_valid), 0);
    check(hdr_word == 14'd0, "R11 word zero", int'(hdr_word), 0);
  endtask

  task automatic t_tick_pattern();
    int gap;
    start_acq();
    gap = 0;
    while (!smp_tick) begin @(negedge clk); gap++; end
    check(gap == 3, "R1 first strobe", gap, 3);
    for (int k = 0; k < 4; k++) begin
      gap = 0;
      @(negedge clk); gap++;
      while (!smp_tick) begin @(negedge clk); gap++; end
      check(gap == ((k % 2 == 0) ? 3 : 4), "R1 strobe gap", gap, (k % 2 == 0) ? 3 : 4);
    end
  endtask

  task automatic t_rf_and_sample();
    logic [13:0] w;
    set_src(3'd4);
    start_acq();
    wait_word(w); check(w[8:0] == 9'd3,  "R2 rf word1", int'(w[8:0]), 3);
    check(hdr_valid == 1'b1, "R9 valid after strobe", int'(hdr_valid), 1);
    wait_word(w); check(w[8:0] == 9'd6,  "R2 rf word2", int'(w[8:0]), 6);
    wait_word(w); check(w[8:0] == 9'd10, "R8 R2 rf word3", int'(w[8:0]), 10);
    set_src(3'd3);
    start_acq();
    wait_word(w); check(w[8:0] == 9'd0, "R2 sample word1", int'(w[8:0]), 0);
    wait_word(w); check(w[8:0] == 9'd1, "R2 sample word2", int'(w[8:0]), 1);
    wait_word(w); check(w[8:0] == 9'd2, "R2 sample word3", int'(w[8:0]), 2);
  endtask

  task automatic t_beam_counts();
    logic [13:0] w;
    set_src(3'd2);
    start_acq();
    proton_mark = 1'b1; pbar_mark = 1'b1; @(negedge clk);
    proton_mark = 1'b0; pbar_mark = 1'b0; @(negedge clk);
    proton_mark = 1'b1; @(negedge clk); proton_mark = 1'b0; @(negedge clk);
    pbar_mark = 1'b1;   @(negedge clk); pbar_mark = 1'b0;
    wait_word(w); wait_word(w);
    check(w[8:0] == 9'd3, "R3 either count", int'(w[8:0]), 3);
    set_src(3'd0);
    wait_word(w); check(w[8:0] == 9'd2, "R3 proton count", int'(w[8:0]), 2);
    set_src(3'd1);
    wait_word(w); check(w[8:0] == 9'd2, "R3 pbar count", int'(w[8:0]), 2);
    set_src(3'd0);
    start_acq();
    wait_word(w); check(w[8:0] == 9'd0, "R8 proton cleared", int'(w[8:0]), 0);
  endtask

  task automatic t_sticky();
    logic [13:0] w;
    wait_word(w);
    inj_mark = 1'b1; @(negedge clk); inj_mark = 1'b0;
    proton_mark = 1'b1; @(negedge clk); proton_mark = 1'b0;
    wait_word(w);
    check(w[9] == 1'b1,  "R5 inject bit set", int'(w[9]), 1);
    check(w[12] == 1'b1, "R5 proton bit set", int'(w[12]), 1);
    check(w[11] == 1'b0, "R5 pbar bit idle", int'(w[11]), 0);
    wait_word(w);
    check(w[9] == 1'b0,  "R5 inject cleared", int'(w[9]), 0);
    check(w[12] == 1'b0, "R5 proton cleared", int'(w[12]), 0);
  endtask

  task automatic t_same_edge();
    logic [13:0] w;
    wait_word(w);
    while (!smp_tick) @(negedge clk);
    pbar_mark = 1'b1; @(negedge clk); pbar_mark = 1'b0;
    check(hdr_word[11] == 1'b0, "R6 not in current word", int'(hdr_word[11]), 0);
    wait_word(w);
    check(w[11] == 1'b1, "R6 in following word", int'(w[11]), 1);
  endtask

  task automatic t_src_boundary();
    logic [13:0] w;
    set_src(3'd4);
    start_acq();
    wait_word(w);
    @(negedge clk); src_sel = 3'd3;
    wait_word(w); check(w[8:0] == 9'd6, "R7 old source kept", int'(w[8:0]), 6);
    wait_word(w); check(w[8:0] == 9'd2, "R7 new source used", int'(w[8:0]), 2);
  endtask

  task automatic t_layout();
    logic [13:0] w;
    cal_mode = 1'b1; data_valid = 1'b1;
    wait_word(w);
    check(w[13] == 1'b1, "R4 cal bit", int'(w[13]), 1);
    check(w[10] == 1'b1, "R4 data valid bit", int'(w[10]), 1);
    cal_mode = 1'b0; data_valid = 1'b0;
    wait_word(w);
    check(w[13:9] == 5'd0, "R4 flag bits clear", int'(w[13:9]), 0);
  endtask

  task automatic t_handshake();
    logic [13:0] w;
    hdr_ready = 1'b0;
    wait_word(w);
    @(negedge clk);
    check(hdr_valid == 1'b1, "R9 valid held", int'(hdr_valid), 1);
    check(hdr_word == w, "R9 word stable", int'(hdr_word), int'(w));
    hdr_ready = 1'b1;
    @(negedge clk);
    check(hdr_valid == 1'b0, "R9 valid dropped", int'(hdr_valid), 0);
  endtask

  task automatic t_wrap();
    logic [13:0] w;
    set_src(3'd4);
    start_acq();
    for (int k = 0; k < 150; k++) wait_word(w);
    check(w[8:0] == 9'd12, "R10 field wraps", int'(w[8:0]), 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_tick_pattern();
    t_rf_and_sample();
    t_beam_counts();
    t_sticky();
    t_same_edge();
    t_src_boundary();
    t_layout();
    t_handshake();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule